// File: doc/BRIEF.md
# Four-Channel Double-Buffered DAC Code Register Bank

This block is the digital front end of a four-channel, 8-bit digital-to-analog converter. A host sends 11-bit command words over a two-wire serial link made of a data line and a clock line. Each word names a channel, gives a range flag and gives an 8-bit code. A low pulse on the load strobe then writes the range flag and the code into the staging latch of the named channel.

Every channel has two register levels: a staging latch and an output register. A low level on the update strobe copies all four staging latches into the output registers on the same clock edge, so the host can prepare a full set of new values and then switch all four outputs at once. If the update strobe is tied low, each output register follows its staging latch one cycle after that latch is written. The outputs are the four codes and four range flags. The range flag only chooses between a span of one or two times the reference on the analog side, and it is stored and presented here unchanged.

All four serial-side inputs are asynchronous to the system clock. Each one passes through a multi-stage synchronizer, and edges are detected in the system clock domain.

Top module: `quad_dac_regbank`

## Requirements
- R1: A synchronous active-high reset sets every staging latch and every output register to code 0 and range 0. After reset, an update pulse with no new writes leaves all outputs at 0.
- R2: On each falling edge of the serial clock, the shift register takes in one bit from the data line, so the first bit received ends up most significant. After 11 bits, word bits [10:9] hold the channel number (00 to 11 selects channels 0 to 3), bit [8] holds the range flag and bits [7:0] hold the code, most significant bit first.
- R3: A falling edge of the load strobe writes the range flag and code from the shift register into the staging latch of the selected channel only. The other three staging latches keep their values.
- R4: While the update strobe is high, the output registers do not change, whatever is shifted or loaded.
- R5: While the update strobe is low, all four output registers take the values of their staging latches on the same clock edge.
- R6: With the update strobe held low, an output register shows the new value of its staging latch right after each load.
- R7: Serial clock falling edges that occur while the load strobe is low are ignored. The shift register keeps its contents, so a later load pulse writes the word that was shifted in before.
- R8: The stored range flag of channel n appears on range output bit n. Code n appears on code output bits [8n+7:8n].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Asynchronous serial clock; data is taken on its falling edge |
| ser_dat_i | input | 1 | Asynchronous serial data, channel bits first, code MSB last group |
| load_n_i | input | 1 | Asynchronous active-low load strobe; its falling edge writes a staging latch |
| update_n_i | input | 1 | Asynchronous active-low update level; copies staging latches to outputs |
| code_o | output | 32 | Output codes, channel n in bits [8n+7:8n] |
| range_o | output | 4 | Output range flags, channel n in bit n |

## Verification
Random words go to random channels while the update strobe is held high. These show that loads reach only the addressed staging latch and never reach the outputs early. Directed writes of distinct, asymmetric codes such as 0x01, 0x80 and 0xA5 to all four channels, followed by one update pulse, tell apart a wrong channel decode, a reversed bit order and outputs that change in different cycles. The bench records the cycle in which each channel first changes. A second phase holds update low and checks that each output follows its own load right away. Junk bits clocked in while load is low, followed by a reload, separate a correctly gated shift register from one that still shifts. A reset in the middle of the run followed by a bare update pulse shows that the staging level was also cleared.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NUM_CH  = 4;
    localparam int CODE_W  = 8;
    localparam int SEL_W   = $clog2(NUM_CH);
    localparam int FRAME_W = SEL_W + 1 + CODE_W;

    // serial-side control lines, by position in the synchronizer vector
    localparam int CTL_W    = 4;
    localparam int IDX_SCLK = 0;
    localparam int IDX_SDAT = 1;
    localparam int IDX_LOAD = 2;
    localparam int IDX_UPD  = 3;

    // which control lines need a falling-edge detector
    localparam int EDGE_W   = 2;
    localparam int EDG_SCLK = 0;
    localparam int EDG_LOAD = 1;

    typedef struct packed {
        logic              rng;
        logic [CODE_W-1:0] code;
    } chan_word_t;

    localparam int WORD_W = $bits(chan_word_t);

    // MSBs hold the channel select, since those bits arrive first
    typedef struct packed {
        logic [SEL_W-1:0] sel;
        chan_word_t       word;
    } frame_t;

    function automatic frame_t unpack_frame(input logic [FRAME_W-1:0] raw);
        return frame_t'(raw);
    endfunction

    function automatic logic [NUM_CH-1:0] sel_onehot(input logic [SEL_W-1:0] sel);
        logic [NUM_CH-1:0] oh;
        oh = '0;
        oh[sel] = 1'b1;
        return oh;
    endfunction

endpackage

// File: rtl/qdac_input_sync.sv
module qdac_input_sync #(
    parameter int              WIDTH  = 4,
    parameter int              STAGES = 2,
    parameter logic [WIDTH-1:0] IDLE  = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] level_o
);
    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{IDLE}};
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign level_o = chain_q[STAGES-1];

endmodule

// File: rtl/qdac_fall_detect.sv
module qdac_fall_detect #(
    parameter int              WIDTH = 2,
    parameter logic [WIDTH-1:0] IDLE = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] fall_o
);
    logic [WIDTH-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= IDLE;
        else     prev_q <= level_i;
    end

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        assign fall_o[b] = prev_q[b] & ~level_i[b];
    end

endmodule

// File: rtl/qdac_shift_reg.sv
module qdac_shift_reg #(
    parameter int WIDTH = 11
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] frame_q
);
    always_ff @(posedge clk) begin
        if (rst)           frame_q <= '0;
        else if (shift_en) frame_q <= {frame_q[WIDTH-2:0], bit_in};
    end

endmodule

// File: rtl/qdac_channel.sv
module qdac_channel
    import qdac_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  chan_word_t wr_word,
    input  logic       upd_en,
    output chan_word_t held_o,
    output chan_word_t out_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            held_o <= '0;
            out_o  <= '0;
        end else begin
            if (wr_en)  held_o <= wr_word;
            if (upd_en) out_o  <= held_o;
        end
    end

endmodule

// File: rtl/quad_dac_regbank.sv
module quad_dac_regbank
    import qdac_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     ser_clk_i,
    input  logic                     ser_dat_i,
    input  logic                     load_n_i,
    input  logic                     update_n_i,
    output logic [NUM_CH*CODE_W-1:0] code_o,
    output logic [NUM_CH-1:0]        range_o
);
    logic [CTL_W-1:0]  ctl_raw, ctl_lvl;
    logic [EDGE_W-1:0] edge_lvl, edge_fall;

    assign ctl_raw[IDX_SCLK] = ser_clk_i;
    assign ctl_raw[IDX_SDAT] = ser_dat_i;
    assign ctl_raw[IDX_LOAD] = load_n_i;
    assign ctl_raw[IDX_UPD]  = update_n_i;

    qdac_input_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES), .IDLE('1)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (ctl_raw),
        .level_o (ctl_lvl)
    );

    assign edge_lvl[EDG_SCLK] = ctl_lvl[IDX_SCLK];
    assign edge_lvl[EDG_LOAD] = ctl_lvl[IDX_LOAD];

    qdac_fall_detect #(.WIDTH(EDGE_W), .IDLE('1)) u_fall (
        .clk     (clk),
        .rst     (rst),
        .level_i (edge_lvl),
        .fall_o  (edge_fall)
    );

    // serial clock falls only count while load is released
    logic shift_fire, load_fire, upd_active, sdat_lvl;
    assign shift_fire = edge_fall[EDG_SCLK] & ctl_lvl[IDX_LOAD];
    assign load_fire  = edge_fall[EDG_LOAD];
    assign upd_active = ~ctl_lvl[IDX_UPD];
    assign sdat_lvl   = ctl_lvl[IDX_SDAT];

    logic [FRAME_W-1:0] frame_q;

    qdac_shift_reg #(.WIDTH(FRAME_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_fire),
        .bit_in   (sdat_lvl),
        .frame_q  (frame_q)
    );

    frame_t            cur_frame;
    logic [NUM_CH-1:0] wr_sel;
    assign cur_frame = unpack_frame(frame_q);
    assign wr_sel    = sel_onehot(cur_frame.sel) & {NUM_CH{load_fire}};

    chan_word_t                held_w [NUM_CH];
    chan_word_t                out_w  [NUM_CH];
    logic [NUM_CH*WORD_W-1:0]  latch_flat;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        qdac_channel u_chan (
            .clk     (clk),
            .rst     (rst),
            .wr_en   (wr_sel[ch]),
            .wr_word (cur_frame.word),
            .upd_en  (upd_active),
            .held_o  (held_w[ch]),
            .out_o   (out_w[ch])
        );
        assign code_o[ch*CODE_W +: CODE_W]     = out_w[ch].code;
        assign range_o[ch]                     = out_w[ch].rng;
        assign latch_flat[ch*WORD_W +: WORD_W] = held_w[ch];
    end

endmodule

// File: rtl/qdac_checker.sv
module qdac_checker
    import qdac_pkg::*;
(
    input logic                     clk,
    input logic                     rst,
    input logic [NUM_CH*CODE_W-1:0] code_o,
    input logic [NUM_CH-1:0]        range_o,
    input logic [NUM_CH*WORD_W-1:0] latch_flat,
    input logic [FRAME_W-1:0]       frame_q,
    input logic                     shift_fire,
    input logic                     load_fire,
    input logic                     upd_active,
    input logic                     sdat_lvl
);
    logic [NUM_CH*WORD_W-1:0] out_flat;
    logic [NUM_CH*WORD_W-1:0] latch_prev;
    logic [NUM_CH-1:0]        latch_chg;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_map
        assign out_flat[ch*WORD_W +: WORD_W] = {range_o[ch], code_o[ch*CODE_W +: CODE_W]};
        assign latch_chg[ch] = latch_prev[ch*WORD_W +: WORD_W] != latch_flat[ch*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) latch_prev <= '0;
        else     latch_prev <= latch_flat;
    end

    // R1: outputs leave reset cleared
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (code_o == '0 && range_o == '0 && latch_flat == '0));

    // R2: one accepted serial edge shifts the sampled bit into the LSB
    assert_shift_order_R2: assert property (@(posedge clk) disable iff (rst)
        $past(shift_fire) |-> frame_q == {$past(frame_q[FRAME_W-2:0]), $past(sdat_lvl)});

    // R3: staging latches move only after a load edge
    assert_latch_by_load_R3: assert property (@(posedge clk) disable iff (rst)
        !$stable(latch_flat) |-> $past(load_fire));

    // R3: never more than one staging latch changes at a time
    assert_single_channel_R3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(latch_chg));

    // R4: outputs hold while update is released
    assert_out_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(out_flat) |-> $past(upd_active));

    // R5 / R6: an active update makes every output equal its staging latch
    assert_out_copy_R5: assert property (@(posedge clk) disable iff (rst)
        $past(upd_active) |-> out_flat == $past(latch_flat));

    // R7: shift register holds unless an accepted serial edge came
    assert_shift_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !$stable(frame_q) |-> $past(shift_fire));

endmodule

bind quad_dac_regbank qdac_checker u_qdac_checker (
    .clk        (clk),
    .rst        (rst),
    .code_o     (code_o),
    .range_o    (range_o),
    .latch_flat (latch_flat),
    .frame_q    (frame_q),
    .shift_fire (shift_fire),
    .load_fire  (load_fire),
    .upd_active (upd_active),
    .sdat_lvl   (sdat_lvl)
);

// File: tb/tb_quad_dac_regbank.sv
`timescale 1ns/1ps
module tb_quad_dac_regbank;
    import qdac_pkg::*;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst, sclk, sdat, load_n, upd_n;
    logic [NUM_CH*CODE_W-1:0] code_o;
    logic [NUM_CH-1:0]        range_o;

    quad_dac_regbank dut (
        .clk        (clk),
        .rst        (rst),
        .ser_clk_i  (sclk),
        .ser_dat_i  (sdat),
        .load_n_i   (load_n),
        .update_n_i (upd_n),
        .code_o     (code_o),
        .range_o    (range_o)
    );

    int checks = 0;
    int fails  = 0;

    logic [CODE_W-1:0] stg_code [NUM_CH];
    logic              stg_rng  [NUM_CH];
    logic [CODE_W-1:0] exp_code [NUM_CH];
    logic              exp_rng  [NUM_CH];

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [FRAME_W-1:0] make_frame(input int ch, input logic r, input logic [CODE_W-1:0] c);
        logic [SEL_W-1:0] s;
        s = ch[SEL_W-1:0];
        return {s, r, c};
    endfunction

    task automatic shift_frame(input logic [FRAME_W-1:0] f);
        for (int i = FRAME_W - 1; i >= 0; i--) begin
            @(negedge clk);
            sdat = f[i];
            sclk = 1'b1;
            idle(3);
            sclk = 1'b0;
            idle(3);
        end
        @(negedge clk);
        sclk = 1'b1;
        idle(2);
    endtask

    task automatic pulse_load();
        @(negedge clk);
        load_n = 1'b0;
        idle(4);
        load_n = 1'b1;
        idle(5);
    endtask

    task automatic write_ch(input int ch, input logic r, input logic [CODE_W-1:0] c);
        shift_frame(make_frame(ch, r, c));
        pulse_load();
        stg_code[ch] = c;
        stg_rng[ch]  = r;
        if (upd_n == 1'b0) begin
            exp_code[ch] = c;
            exp_rng[ch]  = r;
        end
    endtask

    task automatic check_outputs(input string tag);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            chk(code_o[ch*CODE_W +: CODE_W] == exp_code[ch], $sformatf("%s code ch%0d", tag, ch),
                32'(code_o[ch*CODE_W +: CODE_W]), 32'(exp_code[ch]));
            chk(range_o[ch] == exp_rng[ch], $sformatf("%s R8 range ch%0d", tag, ch),
                32'(range_o[ch]), 32'(exp_rng[ch]));
        end
    endtask

    // pulse update, record the cycle in which each output first moves
    task automatic update_and_check_simul(input string tag);
        logic [NUM_CH*CODE_W-1:0] old_code;
        logic [NUM_CH-1:0]        old_rng;
        int first_chg [NUM_CH];
        int ref_cyc;
        old_code = code_o;
        old_rng  = range_o;
        for (int ch = 0; ch < NUM_CH; ch++) first_chg[ch] = -1;
        @(negedge clk);
        upd_n = 1'b0;
        for (int cyc = 0; cyc < 12; cyc++) begin
            @(negedge clk);
            if (cyc == 2) upd_n = 1'b1;
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (first_chg[ch] < 0 &&
                    (code_o[ch*CODE_W +: CODE_W] != old_code[ch*CODE_W +: CODE_W] ||
                     range_o[ch] != old_rng[ch]))
                    first_chg[ch] = cyc;
            end
        end
        ref_cyc = -1;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            exp_code[ch] = stg_code[ch];
            exp_rng[ch]  = stg_rng[ch];
            if ({stg_rng[ch], stg_code[ch]} != {old_rng[ch], old_code[ch*CODE_W +: CODE_W]}) begin
                if (ref_cyc < 0) ref_cyc = first_chg[ch];
                chk(first_chg[ch] == ref_cyc && first_chg[ch] >= 0,
                    $sformatf("%s R5 same-cycle ch%0d", tag, ch), 32'(first_chg[ch]), 32'(ref_cyc));
            end
        end
        check_outputs({tag, " R5 copy"});
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        idle(4);
        rst = 1'b0;
        idle(2);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            stg_code[ch] = '0; stg_rng[ch] = 1'b0;
            exp_code[ch] = '0; exp_rng[ch] = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0D0C));
        rst = 1'b1; sclk = 1'b1; sdat = 1'b0; load_n = 1'b1; upd_n = 1'b1;
        for (int ch = 0; ch < NUM_CH; ch++) begin
            stg_code[ch] = '0; stg_rng[ch] = 1'b0;
            exp_code[ch] = '0; exp_rng[ch] = 1'b0;
        end
        idle(5);
        rst = 1'b0;
        idle(3);
        check_outputs("R1 reset");

        // directed: distinct asymmetric codes, update held high
        write_ch(0, 1'b0, 8'h01);
        write_ch(1, 1'b1, 8'h80);
        write_ch(2, 1'b0, 8'hA5);
        write_ch(3, 1'b1, 8'h3C);
        check_outputs("R4 hold after loads");
        update_and_check_simul("R2 R3 directed");

        // overwrite one channel only, others must stay
        write_ch(2, 1'b1, 8'hFE);
        check_outputs("R4 hold single");
        update_and_check_simul("R3 single-channel");

        // random writes with update held high, periodic update
        for (int it = 0; it < 40; it++) begin
            int ch;
            logic r;
            logic [CODE_W-1:0] c;
            ch = int'($urandom_range(NUM_CH - 1, 0));
            r  = 1'($urandom);
            c  = 8'($urandom);
            write_ch(ch, r, c);
            if (it % 8 == 7) update_and_check_simul("R5 random");
            else             check_outputs("R4 random hold");
        end

        // all four distinct from present outputs, then one update
        for (int ch = 0; ch < NUM_CH; ch++)
            write_ch(ch, ~exp_rng[ch], ~exp_code[ch]);
        check_outputs("R4 hold all four");
        update_and_check_simul("R5 all four");

        // transparent mode: update held low
        @(negedge clk);
        upd_n = 1'b0;
        idle(3);
        for (int ch = 0; ch < NUM_CH; ch++) begin
            exp_code[ch] = stg_code[ch]; exp_rng[ch] = stg_rng[ch];
        end
        for (int it = 0; it < 12; it++) begin
            int ch;
            ch = int'($urandom_range(NUM_CH - 1, 0));
            write_ch(ch, 1'($urandom), 8'($urandom));
            check_outputs("R6 follow");
        end

        // serial edges while load is low are ignored
        write_ch(2, 1'b1, 8'h5A);
        write_ch(0, 1'b0, 8'h11);
        check_outputs("R6 before gate");
        @(negedge clk);
        load_n = 1'b0;
        shift_frame(make_frame(1, 1'b1, 8'hFF));
        @(negedge clk);
        load_n = 1'b1;
        idle(5);
        check_outputs("R7 junk during load");
        pulse_load();
        check_outputs("R7 reload keeps old word");

        // reset mid-run clears staging level as well
        @(negedge clk);
        upd_n = 1'b1;
        write_ch(3, 1'b1, 8'h99);
        do_reset();
        check_outputs("R1 mid-run reset");
        update_and_check_simul("R1 staging cleared");

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule